// File: doc/BRIEF.md
# Debug-Port Memory Loader Sequencer

This block acts as the master of a four-wire boundary-scan test port and places a block of data into the memory of a target processor that cannot be written directly over that port. It first pulls the target's system reset and test reset low together. It then releases the test reset while the system reset is still held, so the target leaves reset stopped in its debug state. Once the target reports that halt, the sequencer loads the destination pointer once. After that it works through the data in bursts.

Each burst carries eight data words, scanned one by one into the target's general registers. A store-multiple instruction with pointer writeback follows; it is flagged to run at full system speed, writes the eight registers to rising addresses and moves the pointer forward. Three no-op scans then drain the target pipeline. Data arrives on a valid/ready stream. A short last burst is filled with zero words, and no stream data is taken for those slots.

The target's scan chain is abstracted as a 33-bit data register. Bits 31:0 hold a data word or an instruction, and bit 32 is the system-speed flag. Bits are shifted least significant first. The test clock comes from the system clock through a parameterised divider.

Top module: `jtag_mem_loader`

## Requirements
- R1: On start, test reset and system reset both go low for RST_CYC cycles. Test reset then goes high while system reset stays low for a further RST_CYC cycles, so system reset always rises with test reset already high.
- R2: After the reset phase, the test port sees five TMS-high clocks followed by one TMS-low clock. A single instruction scan of IR_W bits then loads the debug chain code IR_CODE, sent LSB first.
- R3: The sequencer repeats a 33-bit halt-poll scan with an all-zero payload until the first bit returned on TDO during a poll is 1. Nothing is injected before that.
- R4: Once halted, exactly one scan carries {flag 0, start address}. The address is never scanned again in that run.
- R5: Each burst scans eight words with flag 0, in stream order, before its store.
- R6: After every eight register scans, one scan carries {flag 1, 32'hE8A800FF}: store-multiple of registers 0 to 7 at the pointer in register 8, ascending, with writeback.
- R7: Every store scan is followed by exactly three scans of {flag 0, 32'hE1A00000}, a register-to-itself move, before the next burst or the end of the run.
- R8: When the word count is not a multiple of eight, the last burst fills its unused slots with {flag 0, 0}, and din_ready stays low for those slots. A count of zero gives no bursts.
- R9: A word is consumed only in a cycle with din_valid and din_ready both high. While din_valid is low, the sequencer waits in the register-load step, and the scanned contents are the same as without stalls.
- R10: done is high for exactly one cycle, after the last no-op scan (or after the address scan when the count is zero). busy is high from the cycle after start and falls in the cycle where done rises.
- R11: TCK has a period of 2*HALF_DIV system clocks. TMS and TDI change only together with a falling edge of TCK.
- R12: After reset: busy, done, din_ready, tck, tms and tdi are 0, and trst_n and srst_n are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| start | input | 1 | Pulse in idle to begin a load run |
| start_addr | input | 32 | Destination address for the first word |
| word_count | input | CNT_W | Number of 32-bit words to load |
| din_valid | input | 1 | Stream word present |
| din_data | input | 32 | Stream data word |
| din_ready | output | 1 | Sequencer takes the word this cycle if valid |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |
| trst_n | output | 1 | Active-low test-logic reset to target |
| srst_n | output | 1 | Active-low system reset to target |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |

## Verification
Assertions placed in the RTL check several rules on every cycle:
- pins move only together with a falling TCK edge;
- system reset rises only with test reset high;
- done lasts one cycle, and busy falls only with done;
- no data is requested while padding;
- the shift engine accepts a frame only when idle.

The bench models the target's test-access state machine and pairs every completed data-register scan with an entry in an ordered queue of expected scans. This shows the things that only whole runs can reveal:
- the halt polling;
- the single address load;
- the burst, store and flush ordering;
- zero padding and the data left unconsumed in the stream;
- identical scans with and without input stalls.

// File: rtl/jml_pkg.sv
`timescale 1ns/1ps
package jml_pkg;
   localparam int WORD_W     = 32;
   localparam int SCAN_W     = WORD_W + 1;   // bit 32 = system-speed flag
   localparam int BURST_REGS = 8;
   localparam int NOP_REPS   = 3;
   localparam logic [WORD_W-1:0] STM_OP = 32'hE8A800FF;  // store r0-r7 at [r8], ascending, writeback
   localparam logic [WORD_W-1:0] NOP_OP = 32'hE1A00000;  // move r0 to r0

   typedef enum logic [1:0] {FR_RESET, FR_IR, FR_DR} frame_e;

   typedef enum logic [3:0] {
      S_IDLE, S_RSTA, S_RSTB, S_TLR, S_IRSEL, S_POLL,
      S_ADDR, S_LOAD, S_STORE, S_FLUSH, S_FIN
   } ldr_state_e;
endpackage

// File: rtl/jml_tck_gen.sv
`timescale 1ns/1ps
module jml_tck_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tck,
   output logic rise_tick,
   output logic fall_tick
);
   logic wrap;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_fast
      assign wrap = 1'b1;
   end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      assign wrap = (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (wrap) cnt <= '0;
         else           cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tck <= 1'b0;
      else        tck <= tck ^ wrap;
   end

   assign rise_tick = wrap & ~tck;
   assign fall_tick = wrap &  tck;
endmodule

// File: rtl/jml_shifter.sv
`timescale 1ns/1ps
module jml_shifter
   import jml_pkg::*;
#(
   parameter int IR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic              start,
   input  frame_e            kind,
   input  logic [SCAN_W-1:0] payload,
   input  logic              tdo,
   output logic              tms,
   output logic              tdi,
   output logic              busy,
   output logic              done,
   output logic              first_tdo
);
   localparam int FW = 4 + SCAN_W + 2;
   localparam int LW = $clog2(FW + 1);

   if (IR_W < 2 || IR_W > SCAN_W) begin : g_bad_ir
      $error("IR_W out of range");
   end

   logic [FW-1:0] tms_v, tdi_v, tms_sr, tdi_sr;
   logic [LW-1:0] len_v, cap_v, left, pos, cap_at;

   always_comb begin
      int hdr, plen;
      hdr  = (kind == FR_IR) ? 4 : 3;
      plen = (kind == FR_IR) ? IR_W : SCAN_W;
      tms_v = '0;
      for (int i = 0; i < FW; i++) begin
         if (kind == FR_RESET)  tms_v[i] = (i < 5);
         else if (i < hdr)      tms_v[i] = (kind == FR_IR) ? (i < 2) : (i == 0);
         else                   tms_v[i] = (i >= hdr + plen - 1) && (i <= hdr + plen);
      end
      len_v = (kind == FR_RESET) ? LW'(6) : LW'(hdr + plen + 2);
      tdi_v = (kind == FR_RESET) ? '0 : ({{(FW-SCAN_W){1'b0}}, payload} << hdr);
      cap_v = LW'(hdr + 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tms_sr <= '0; tdi_sr <= '0; left <= '0; pos <= '0; cap_at <= '0;
         tms <= 1'b0; tdi <= 1'b0; busy <= 1'b0; done <= 1'b0; first_tdo <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            tms_sr <= tms_v; tdi_sr <= tdi_v; left <= len_v; cap_at <= cap_v;
            pos <= '0; busy <= 1'b1;
         end else if (busy && fall_tick) begin
            if (left == '0) begin
               busy <= 1'b0; done <= 1'b1; tms <= 1'b0; tdi <= 1'b0;
            end else begin
               tms <= tms_sr[0]; tdi <= tdi_sr[0];
               tms_sr <= tms_sr >> 1; tdi_sr <= tdi_sr >> 1;
               left <= left - 1'b1; pos <= pos + 1'b1;
            end
         end
         if (busy && rise_tick && pos == cap_at) first_tdo <= tdo;
      end
   end

   p_accept_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

// File: rtl/jml_ctrl.sv
`timescale 1ns/1ps
module jml_ctrl
   import jml_pkg::*;
#(
   parameter int CNT_W   = 20,
   parameter int RST_CYC = 16,
   parameter int IR_W    = 4,
   parameter int IR_CODE = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              din_valid,
   input  logic [WORD_W-1:0] din_data,
   output logic              din_ready,
   output logic              sh_start,
   output frame_e            sh_kind,
   output logic [SCAN_W-1:0] sh_payload,
   input  logic              sh_done,
   input  logic              sh_busy,
   input  logic              halt_bit,
   output logic              trst_n,
   output logic              srst_n,
   output logic              busy,
   output logic              done
);
   localparam int SW  = $clog2(BURST_REGS);
   localparam int RCW = $clog2(RST_CYC + 1);

   if (CNT_W < 19) begin : g_bad_cnt
      $error("CNT_W too narrow for 16-bit burst count");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end

   ldr_state_e        state;
   logic [WORD_W-1:0] addr_q;
   logic [CNT_W-1:0]  words_left, bursts_left;
   logic [SW-1:0]     slot;
   logic [1:0]        nops;
   logic [RCW-1:0]    rcnt;
   logic              pending, pad, in_frame, pop;
   logic [CNT_W:0]    bursts_ext;

   assign pad        = (words_left == '0);
   assign in_frame   = state inside {S_TLR, S_IRSEL, S_POLL, S_ADDR, S_LOAD, S_STORE, S_FLUSH};
   assign din_ready  = (state == S_LOAD) && !pending && !sh_busy && !pad;
   assign pop        = din_ready && din_valid;
   assign sh_start   = in_frame && !pending && !sh_busy &&
                       ((state != S_LOAD) || pad || din_valid);
   assign bursts_ext = ({1'b0, word_count} + (CNT_W+1)'(BURST_REGS - 1)) >> SW;

   always_comb begin
      sh_kind    = FR_DR;
      sh_payload = '0;
      case (state)
         S_TLR:   sh_kind = FR_RESET;
         S_IRSEL: begin sh_kind = FR_IR; sh_payload = SCAN_W'(IR_W'(IR_CODE)); end
         S_ADDR:  sh_payload = {1'b0, addr_q};
         S_LOAD:  sh_payload = {1'b0, pad ? '0 : din_data};
         S_STORE: sh_payload = {1'b1, STM_OP};
         S_FLUSH: sh_payload = {1'b0, NOP_OP};
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; addr_q <= '0; words_left <= '0; bursts_left <= '0;
         slot <= '0; nops <= '0; rcnt <= '0; pending <= 1'b0;
         busy <= 1'b0; done <= 1'b0; trst_n <= 1'b1; srst_n <= 1'b1;
      end else begin
         done   <= 1'b0;
         trst_n <= (state != S_RSTA);
         srst_n <= !(state inside {S_RSTA, S_RSTB});
         if (sh_start) pending <= 1'b1;
         if (pop) words_left <= words_left - 1'b1;
         case (state)
            S_IDLE: if (start) begin
               addr_q <= start_addr; words_left <= word_count;
               bursts_left <= CNT_W'(bursts_ext);
               rcnt <= '0; busy <= 1'b1; state <= S_RSTA;
            end
            S_RSTA, S_RSTB: begin
               if (rcnt == RCW'(RST_CYC - 1)) begin
                  rcnt  <= '0;
                  state <= (state == S_RSTA) ? S_RSTB : S_TLR;
               end else rcnt <= rcnt + 1'b1;
            end
            S_FIN: begin done <= 1'b1; busy <= 1'b0; state <= S_IDLE; end
            default: if (sh_done) begin
               pending <= 1'b0;
               case (state)
                  S_TLR:   state <= S_IRSEL;
                  S_IRSEL: state <= S_POLL;
                  S_POLL:  if (halt_bit) state <= S_ADDR;
                  S_ADDR:  begin slot <= '0; state <= (bursts_left == '0) ? S_FIN : S_LOAD; end
                  S_LOAD:  if (slot == SW'(BURST_REGS - 1)) state <= S_STORE;
                           else slot <= slot + 1'b1;
                  S_STORE: begin nops <= '0; state <= S_FLUSH; end
                  S_FLUSH: if (nops == 2'(NOP_REPS - 1)) begin
                              bursts_left <= bursts_left - 1'b1;
                              slot  <= '0;
                              state <= (bursts_left == CNT_W'(1)) ? S_FIN : S_LOAD;
                           end else nops <= nops + 1'b1;
                  default: ;
               endcase
            end
         endcase
      end
   end

   p_halt_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst_n) |-> trst_n);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_no_pad_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (words_left == '0) |-> !din_ready);
endmodule

// File: rtl/jtag_mem_loader.sv
`timescale 1ns/1ps
module jtag_mem_loader
   import jml_pkg::*;
#(
   parameter int HALF_DIV = 4,
   parameter int CNT_W    = 20,
   parameter int RST_CYC  = 16,
   parameter int IR_W     = 4,
   parameter int IR_CODE  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      start_addr,
   input  logic [CNT_W-1:0] word_count,
   input  logic             din_valid,
   input  logic [31:0]      din_data,
   output logic             din_ready,
   output logic             tck,
   output logic             tms,
   output logic             tdi,
   input  logic             tdo,
   output logic             trst_n,
   output logic             srst_n,
   output logic             busy,
   output logic             done
);
   logic              rise_tick, fall_tick, sh_start, sh_done, sh_busy, halt_bit;
   frame_e            sh_kind;
   logic [SCAN_W-1:0] sh_payload;

   jml_tck_gen #(.HALF_DIV(HALF_DIV)) u_tck (
      .clk(clk), .rst_n(rst_n), .tck(tck),
      .rise_tick(rise_tick), .fall_tick(fall_tick));

   jml_shifter #(.IR_W(IR_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
      .start(sh_start), .kind(sh_kind), .payload(sh_payload), .tdo(tdo),
      .tms(tms), .tdi(tdi), .busy(sh_busy), .done(sh_done), .first_tdo(halt_bit));

   jml_ctrl #(.CNT_W(CNT_W), .RST_CYC(RST_CYC), .IR_W(IR_W), .IR_CODE(IR_CODE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .din_valid(din_valid), .din_data(din_data),
      .din_ready(din_ready), .sh_start(sh_start), .sh_kind(sh_kind),
      .sh_payload(sh_payload), .sh_done(sh_done), .sh_busy(sh_busy),
      .halt_bit(halt_bit), .trst_n(trst_n), .srst_n(srst_n),
      .busy(busy), .done(done));

   p_pins_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(tck) |-> ($stable(tms) && $stable(tdi)));
endmodule

// File: tb/jtag_mem_loader_bench.sv
`timescale 1ns/1ps
module jtag_mem_loader_bench;
   localparam int HALF  = 2;
   localparam int CNT_W = 20;
   localparam logic [31:0] STM = 32'hE8A800FF;
   localparam logic [31:0] NOP = 32'hE1A00000;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, din_valid = 1'b0, tdo = 1'b0;
   logic [31:0] start_addr = '0, din_data = '0;
   logic [CNT_W-1:0] word_count = '0;
   logic din_ready, tck, tms, tdi, trst_n, srst_n, busy, done;

   always #10 clk = ~clk;

   jtag_mem_loader #(.HALF_DIV(HALF), .CNT_W(CNT_W), .RST_CYC(4), .IR_W(4), .IR_CODE(12))
   u_jtag_mem_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .din_valid(din_valid), .din_data(din_data),
      .din_ready(din_ready), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
      .trst_n(trst_n), .srst_n(srst_n), .busy(busy), .done(done));

   int checks = 0, errors = 0;
   logic [32:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] dq[$];
   bit   stall_mode = 0;
   int   done_cnt = 0, ir_cnt = 0, caps = 0;
   bit   halted = 0;
   time  t_prev = 0, t_per = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // target model: test-access state machine and a 33-bit data register
   localparam int TLR=0, RTI=1, SDR=2, CDR=3, SHDR=4, E1DR=5, PDR=6, E2DR=7, UDR=8,
                  SIR=9, CIR=10, SHIR=11, E1IR=12, PIR=13, E2IR=14, UIR=15;
   int st = TLR, dr_n = 0, ir_n = 0;
   logic [32:0] sr = '0;
   logic [3:0]  ir = '0;

   always @(negedge tck) tdo = sr[0];

   always @(posedge tck) begin
      if (t_prev != 0) t_per = $time - t_prev;
      t_prev = $time;
      if (!trst_n) st = TLR;
      else begin
         case (st)
            CDR:  begin sr = {32'b0, (halted && caps >= 1)}; caps++; dr_n = 0; end
            SHDR: begin sr = {tdi, sr[32:1]}; dr_n++; end
            CIR:  begin ir_n = 0; end
            SHIR: begin ir = {tdi, ir[3:1]}; ir_n++; end
            UDR: begin
               if (exp_q.size() == 0) chk(0, "R5", 64'(sr), 64'hX);
               else begin
                  logic [32:0] e; string t;
                  e = exp_q.pop_front(); t = tag_q.pop_front();
                  chk(sr == e && dr_n == 33, t, 64'(sr), 64'(e));
               end
            end
            UIR: begin
               ir_cnt++;
               chk(ir == 4'hC && ir_n == 4, "R2", 64'(ir), 64'hC);
            end
            default: ;
         endcase
         case (st)
            TLR:  st = tms ? TLR  : RTI;
            RTI:  st = tms ? SDR  : RTI;
            SDR:  st = tms ? SIR  : CDR;
            CDR:  st = tms ? E1DR : SHDR;
            SHDR: st = tms ? E1DR : SHDR;
            E1DR: st = tms ? UDR  : PDR;
            PDR:  st = tms ? E2DR : PDR;
            E2DR: st = tms ? UDR  : SHDR;
            UDR:  st = tms ? SDR  : RTI;
            SIR:  st = tms ? TLR  : CIR;
            CIR:  st = tms ? E1IR : SHIR;
            SHIR: st = tms ? E1IR : SHIR;
            E1IR: st = tms ? UIR  : PIR;
            PIR:  st = tms ? E2IR : PIR;
            E2IR: st = tms ? UIR  : SHIR;
            default: st = tms ? SDR : RTI;
         endcase
      end
   end

   // halt entry: system reset released while test reset is high (R1)
   always @(posedge srst_n) if (rst_n) begin
      chk(trst_n == 1'b1, "R1", 64'(trst_n), 64'd1);
      halted = trst_n;
   end

   always @(negedge clk) if (done) done_cnt++;

   // stream driver (R9 stalls)
   initial begin
      bit fire; int cyc;
      fire = 0; cyc = 0;
      forever begin
         @(negedge clk);
         if (fire && dq.size() > 0) void'(dq.pop_front());
         cyc++;
         if (dq.size() > 0 && !(stall_mode && (cyc % 5 < 2))) begin
            din_valid = 1'b1; din_data = dq[0];
         end else din_valid = 1'b0;
         fire = din_valid && din_ready;
      end
   end

   task automatic push_exp(input logic [32:0] v, input string t);
      exp_q.push_back(v); tag_q.push_back(t);
   endtask

   task automatic run(input logic [31:0] a, input int n, input bit stall);
      int nb, d0;
      exp_q.delete(); tag_q.delete(); dq.delete();
      stall_mode = stall; caps = 0; halted = 0; ir_cnt = 0;
      for (int i = 0; i < n; i++) dq.push_back(32'hC0DE0000 ^ (n << 12) ^ i);
      dq.push_back(32'hDEADBEEF);
      push_exp(33'h0, "R3"); push_exp(33'h0, "R3");
      push_exp({1'b0, a}, "R4");
      nb = (n + 7) / 8;
      for (int b = 0; b < nb; b++) begin
         for (int s = 0; s < 8; s++) begin
            if (b*8 + s < n) push_exp({1'b0, 32'hC0DE0000 ^ (n << 12) ^ (b*8 + s)}, "R5");
            else             push_exp(33'h0, "R8");
         end
         push_exp({1'b1, STM}, "R6");
         for (int k = 0; k < 3; k++) push_exp({1'b0, NOP}, "R7");
      end
      d0 = done_cnt;
      @(negedge clk); start = 1'b1; start_addr = a; word_count = CNT_W'(n);
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R10", 64'(busy), 64'd1);
      while (done_cnt == d0) @(negedge clk);
      chk(busy == 1'b0, "R10", 64'(busy), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R10", 64'(done), 64'd0);
      chk(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'd0);
      chk(dq.size() == 1, "R8", 64'(dq.size()), 64'd1);
      chk(ir_cnt == 1, "R2", 64'(ir_cnt), 64'd1);
      chk(t_per == time'(2*HALF*20), "R11", 64'(t_per), 64'(2*HALF*20));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, din_ready, tck, tms, tdi, trst_n, srst_n} == 8'b00000011,
          "R12", 64'({busy, done, din_ready, tck, tms, tdi, trst_n, srst_n}), 64'h03);
      run(32'h0000_1000, 16, 0);
      run(32'h8000_0040, 11, 1);   // padded, stalled
      run(32'h0000_2000, 3, 1);
      run(32'h0000_3000, 0, 0);    // no bursts
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule